// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits beside a two-wire bus master. It frees the bus after a reset, a power loss or a broken transfer, when a slave may still be driving the data line low partway through a byte. When it gets a request, it toggles the clock line with the data line released. It samples the data line near the end of every clock-high phase, and stops pulsing once that line reads high. It then puts a start condition and a stop condition on the bus, so that every slave's protocol logic restarts and the bus is left idle. The sequence ends with a single-cycle done pulse.

If the data line is still low after the last permitted pulse, the block releases both lines and raises a single-cycle fail pulse. It does not generate a start in that case. Each phase length is given in nanoseconds through parameters and is converted to whole system-clock cycles, rounded up. The clock-high phase does not advance while the clock line reads low, so a slave that stretches the clock is tolerated. The inputs are expected to be synchronised to `clk` already. Both line outputs are pull-low enables for open-drain pads.

Top module: `bus_unjam_seq`

## Requirements
- R1: During and after reset, both pull enables are low and the done and fail pulses are low until a request is accepted.
- R2: A request seen in idle starts pulsing. Each pulse is a clock-low phase (`scl_pull`=1) followed by a clock-high phase (`scl_pull`=0), and `sda_pull` stays 0 throughout.
- R3: At the end of each clock-high phase the block samples `sda_in`. A high value ends pulsing, and a low value starts another pulse. No more than `MAX_PULSES` pulses (default 9) are generated.
- R4: Each clock-low phase lasts ceil(LOW_NS·CLK_KHZ/10^6) cycles. Each clock-high phase lasts ceil(HIGH_NS·CLK_KHZ/10^6) cycles if there is no stretching. The defaults are 163 and 75 cycles at 125 MHz.
- R5: Once `sda_in` is seen high, the clock line stays released for the start setup time. Then `sda_pull` rises while the clock line is released and holds for the start hold time. This is the start condition.
- R6: After the start, the clock line is pulled low for one clock-low time with `sda_pull`=1. It is then released for the stop setup time. After that, `sda_pull` falls while the clock is released, which is the stop condition, and `rcv_done` is 1 for exactly that one cycle.
- R7: If `sda_in` is still low at the end of the last permitted pulse, the block produces no start. Both enables go to 0 and `rcv_fail` is 1 for one cycle. Done and fail are never high together.
- R8: The clock-high phase counter advances only in cycles where `scl_in` reads high. A slave holding the clock line low lengthens that phase by the cycles it holds it.
- R9: `rcv_start` is accepted only in idle. A request raised while a sequence runs does not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rcv_start | input | 1 | Request to run a recovery sequence |
| scl_in | input | 1 | Synchronised level of the clock line |
| sda_in | input | 1 | Synchronised level of the data line |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| rcv_done | output | 1 | One-cycle pulse when the stop condition has been issued |
| rcv_fail | output | 1 | One-cycle pulse when the data line never released |

## Verification
A slave model in the bench holds the data line low for a chosen number of clock rises. The hold counts used are zero, three, exactly nine and ten. Zero shows that a single pulse always happens. Three exercises a normal early exit. Nine reaches the cap exactly and must still succeed. Ten must end in fail with no start. In another run the slave stretches the first clock-high phase, which shows whether the high phase stays frozen while the clock line reads low. A run with extra requests injected mid-sequence shows whether those requests are ignored. Back-to-back runs confirm that the sequencer returns cleanly to idle.

// File: rtl/bus_unjam_pkg.sv
package bus_unjam_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_CLK_LOW  = 4'd1,
        ST_CLK_HIGH = 4'd2,
        ST_STA_SU   = 4'd3,
        ST_STA_HD   = 4'd4,
        ST_STO_LOW  = 4'd5,
        ST_STO_SU   = 4'd6,
        ST_DONE     = 4'd7,
        ST_FAIL     = 4'd8
    } bu_state_e;

    typedef struct packed {
        bu_state_e state;
        logic      scl_low;
        logic      sda_low;
        logic      done;
        logic      fail;
    } bu_regs_t;

    // nanoseconds to whole cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned khz);
        longint unsigned p;
        p = (longint'(ns) * longint'(khz) + 64'd999999) / 64'd1000000;
        if (p == 64'd0) p = 64'd1;
        return p[31:0];
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // {pull clock low, pull data low} for each state
    function automatic logic [1:0] line_drive(input bu_state_e s);
        case (s)
            ST_CLK_LOW: return 2'b10;
            ST_STA_HD:  return 2'b01;
            ST_STO_LOW: return 2'b11;
            ST_STO_SU:  return 2'b01;
            default:    return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/bu_phase_timer.sv
module bu_phase_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          freeze,
    output logic          at_zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (!freeze && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/bu_pulse_tally.sv
module bu_pulse_tally #(
    parameter int unsigned MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);
    localparam int unsigned TW = $clog2(MAX_PULSES + 1);

    logic [TW-1:0] tally_d, tally_q;

    always_comb begin
        tally_d = tally_q;
        if (clear)
            tally_d = '0;
        else if (bump && tally_q != TW'(MAX_PULSES))
            tally_d = tally_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tally_q <= '0;
        else        tally_q <= tally_d;
    end

    assign at_limit = (tally_q == TW'(MAX_PULSES));
endmodule

// File: rtl/bus_unjam_seq.sv
module bus_unjam_seq
    import bus_unjam_pkg::*;
#(
    parameter int unsigned CLK_KHZ    = 125000,
    parameter int unsigned LOW_NS     = 1300,
    parameter int unsigned HIGH_NS    = 600,
    parameter int unsigned SU_STA_NS  = 600,
    parameter int unsigned HD_STA_NS  = 600,
    parameter int unsigned SU_STO_NS  = 600,
    parameter int unsigned MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rcv_start,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_pull,
    output logic sda_pull,
    output logic rcv_done,
    output logic rcv_fail
);
    localparam int unsigned LOW_C    = ns_to_cyc(LOW_NS, CLK_KHZ);
    localparam int unsigned HIGH_C   = ns_to_cyc(HIGH_NS, CLK_KHZ);
    localparam int unsigned SU_STA_C = ns_to_cyc(SU_STA_NS, CLK_KHZ);
    localparam int unsigned HD_STA_C = ns_to_cyc(HD_STA_NS, CLK_KHZ);
    localparam int unsigned SU_STO_C = ns_to_cyc(SU_STO_NS, CLK_KHZ);
    localparam int unsigned MAX_C    = max2(max2(LOW_C, HIGH_C),
                                            max2(max2(SU_STA_C, HD_STA_C), SU_STO_C));
    localparam int unsigned CW       = $clog2(MAX_C + 1);

    localparam logic [CW-1:0] LOW_M1    = CW'(LOW_C - 1);
    localparam logic [CW-1:0] HIGH_M1   = CW'(HIGH_C - 1);
    localparam logic [CW-1:0] SU_STA_M1 = CW'(SU_STA_C - 1);
    localparam logic [CW-1:0] HD_STA_M1 = CW'(HD_STA_C - 1);
    localparam logic [CW-1:0] SU_STO_M1 = CW'(SU_STO_C - 1);

    localparam bu_regs_t REGS_RESET = '{state: ST_IDLE, default: '0};

    bu_regs_t      r_d, r_q;
    logic          t_load, t_freeze, t_zero;
    logic [CW-1:0] t_val;
    logic          p_clear, p_bump, p_last;

    bu_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .freeze   (t_freeze),
        .at_zero  (t_zero)
    );

    bu_pulse_tally #(.MAX_PULSES(MAX_PULSES)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (p_clear),
        .bump     (p_bump),
        .at_limit (p_last)
    );

    always_comb begin
        r_d      = r_q;
        t_load   = 1'b0;
        t_val    = '0;
        t_freeze = 1'b0;
        p_clear  = 1'b0;
        p_bump   = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (rcv_start) begin
                    r_d.state = ST_CLK_LOW;
                    t_load    = 1'b1;
                    t_val     = LOW_M1;
                    p_clear   = 1'b1;
                end
            end
            ST_CLK_LOW: begin
                if (t_zero) begin
                    r_d.state = ST_CLK_HIGH;
                    t_load    = 1'b1;
                    t_val     = HIGH_M1;
                    p_bump    = 1'b1;
                end
            end
            ST_CLK_HIGH: begin
                // a slave holding the clock low stretches this phase
                t_freeze = !scl_in;
                if (t_zero && scl_in) begin
                    if (sda_in) begin
                        r_d.state = ST_STA_SU;
                        t_load    = 1'b1;
                        t_val     = SU_STA_M1;
                    end else if (p_last) begin
                        r_d.state = ST_FAIL;
                    end else begin
                        r_d.state = ST_CLK_LOW;
                        t_load    = 1'b1;
                        t_val     = LOW_M1;
                    end
                end
            end
            ST_STA_SU: begin
                if (t_zero) begin
                    r_d.state = ST_STA_HD;
                    t_load    = 1'b1;
                    t_val     = HD_STA_M1;
                end
            end
            ST_STA_HD: begin
                if (t_zero) begin
                    r_d.state = ST_STO_LOW;
                    t_load    = 1'b1;
                    t_val     = LOW_M1;
                end
            end
            ST_STO_LOW: begin
                if (t_zero) begin
                    r_d.state = ST_STO_SU;
                    t_load    = 1'b1;
                    t_val     = SU_STO_M1;
                end
            end
            ST_STO_SU: begin
                if (t_zero) r_d.state = ST_DONE;
            end
            ST_DONE:  r_d.state = ST_IDLE;
            ST_FAIL:  r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase

        {r_d.scl_low, r_d.sda_low} = line_drive(r_d.state);
        r_d.done = (r_d.state == ST_DONE);
        r_d.fail = (r_d.state == ST_FAIL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RESET;
        else        r_q <= r_d;
    end

    assign scl_pull = r_q.scl_low;
    assign sda_pull = r_q.sda_low;
    assign rcv_done = r_q.done;
    assign rcv_fail = r_q.fail;
endmodule

// File: rtl/bus_unjam_chk.sv
module bus_unjam_chk
    import bus_unjam_pkg::*;
#(
    parameter int unsigned CLK_KHZ    = 125000,
    parameter int unsigned LOW_NS     = 1300,
    parameter int unsigned MAX_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_in,
    input logic scl_pull,
    input logic sda_pull,
    input logic rcv_done,
    input logic rcv_fail
);
    localparam int unsigned LOW_C = ns_to_cyc(LOW_NS, CLK_KHZ);
    localparam int unsigned FW    = $clog2(MAX_PULSES + 3) + 1;

    logic [15:0]   low_run_q;
    logic [FW-1:0] fall_cnt_q;
    logic          scl_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            fall_cnt_q <= '0;
            scl_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_pull;
            if (!scl_pull)              low_run_q <= '0;
            else if (low_run_q != '1)   low_run_q <= low_run_q + 1'b1;
            if (rcv_done || rcv_fail)   fall_cnt_q <= '0;
            else if (scl_prev_q && !scl_pull && fall_cnt_q != '1)
                fall_cnt_q <= fall_cnt_q + 1'b1;
        end
    end

    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt_q <= FW'(MAX_PULSES + 1)); // R3

    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_pull) |-> low_run_q >= 16'(LOW_C)); // R4

    AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> (!scl_pull && scl_in)); // R5

    AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_pull); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_done |=> !rcv_done); // R6

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_done |-> (!scl_pull && !sda_pull)); // R6

    AST_FAIL_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_fail |-> (!$past(sda_in) && !scl_pull && !sda_pull)); // R7

    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rcv_done, rcv_fail})); // R7
endmodule

bind bus_unjam_seq bus_unjam_chk #(
    .CLK_KHZ    (CLK_KHZ),
    .LOW_NS     (LOW_NS),
    .MAX_PULSES (MAX_PULSES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .rcv_done (rcv_done),
    .rcv_fail (rcv_fail)
);

// File: tb/tb_bus_unjam_seq.sv
module tb_bus_unjam_seq;
    localparam int CLK_MHZ = 125;
    localparam int MAXP    = 9;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * CLK_MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int LOW_C  = (1300 * 125 + 999) / 1000;
    localparam int HIGH_C = (600 * 125 + 999) / 1000;
    localparam int STA_SU = (600 * 125 + 999) / 1000;
    localparam int STA_HD = (600 * 125 + 999) / 1000;
    localparam int STO_SU = (600 * 125 + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rcv_start = 1'b0;
    logic scl_pull, sda_pull, rcv_done, rcv_fail;
    logic slave_low = 1'b0;
    logic stretch_low = 1'b0;
    logic scl_in, sda_in;

    assign scl_in = !(scl_pull || stretch_low);
    assign sda_in = !(sda_pull || slave_low);

    always #4 clk = ~clk;

    bus_unjam_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rcv_start (rcv_start),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .rcv_done  (rcv_done),
        .rcv_fail  (rcv_fail)
    );

    int total = 0;
    int bad = 0;
    int hold_n = 0;
    int seen = 0;
    int stretch_rem = 0;
    logic prev_pull = 1'b0;
    logic prev_line = 1'b1;
    string idle_tag = "R1";

    // expected {scl_pull, sda_pull, rcv_done, rcv_fail} per cycle
    logic [3:0] exp_q[$];
    string      tag_q[$];

    task automatic push(input int n, input logic [3:0] v, input string t);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endtask

    task automatic tick();
        logic [3:0] e;
        logic [3:0] a;
        string      t;
        logic       line;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = 4'b0000;
            t = idle_tag;
        end
        a = {scl_pull, sda_pull, rcv_done, rcv_fail};
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s at %0t: got %b expected %b", t, $time, a, e);
        end
        // slave behaviour: optional one-off clock stretch, data held for hold_n rises
        if (stretch_low) begin
            stretch_rem--;
            if (stretch_rem == 0) stretch_low = 1'b0;
        end else if (stretch_rem > 0 && !scl_pull && prev_pull) begin
            stretch_low = 1'b1;
        end
        prev_pull = scl_pull;
        line = !(scl_pull || stretch_low);
        if (line && !prev_line) seen++;
        prev_line = line;
        slave_low = (seen < hold_n);
    endtask

    task automatic run(input int h, input int s, input bit poke);
        int n;
        bit ok;
        hold_n = h;
        seen = 0;
        stretch_rem = s;
        stretch_low = 1'b0;
        slave_low = (h > 0);
        ok = (h <= MAXP);
        n = (h == 0) ? 1 : (ok ? h : MAXP);
        for (int p = 1; p <= n; p++) begin
            push(LOW_C, 4'b1000, "R4");
            if (p == 1 && s > 0)      push(HIGH_C + s, 4'b0000, "R8");
            else if (p == n)          push(HIGH_C, 4'b0000, "R3");
            else                      push(HIGH_C, 4'b0000, "R2");
        end
        if (ok) begin
            push(STA_SU, 4'b0000, "R5");
            push(STA_HD, 4'b0100, "R5");
            push(LOW_C,  4'b1100, "R6");
            push(STO_SU, 4'b0100, "R6");
            push(1,      4'b0010, "R6");
        end else begin
            push(1, 4'b0001, "R7");
        end
        idle_tag = poke ? "R9" : "R1";
        rcv_start = 1'b1;
        tick();
        rcv_start = 1'b0;
        for (int i = 0; exp_q.size() > 0; i++) begin
            if (poke && (i == 4 || i == LOW_C + HIGH_C + 2 || exp_q.size() == 2))
                rcv_start = 1'b1;
            tick();
            rcv_start = 1'b0;
        end
        repeat (4) tick();
        slave_low = 1'b0;
        hold_n = 0;
    endtask

    initial begin
        #1_200_000;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        total++;
        if ({scl_pull, sda_pull, rcv_done, rcv_fail} !== 4'b0000) begin
            bad++;
            $display("FAIL R1 reset: got %b expected 0000",
                     {scl_pull, sda_pull, rcv_done, rcv_fail});
        end
        rst_n = 1'b1;
        repeat (5) tick();                 // R1 idle after reset

        if (cyc(1300) != LOW_C) $display("note: cycle helper differs");

        run(0, 0, 1'b0);                   // R2 R5 R6: free bus, one pulse
        run(3, 0, 1'b0);                   // R3: released after three rises
        run(MAXP, 0, 1'b0);                // R3: released on the last allowed pulse
        run(MAXP + 1, 0, 1'b0);            // R7: never released
        run(2, 5, 1'b0);                   // R8: first high phase stretched
        run(4, 0, 1'b1);                   // R9: requests mid-sequence ignored
        run(1, 0, 1'b0);                   // back-to-back return to idle

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule